// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block cleans up one asynchronous pin before an interrupt detector sees it. The raw level first crosses into the system clock domain through two flops. It is then filtered against a debounce window. The window is a 4-bit count of unit ticks, and the length of a unit tick is taken from a slow reference-clock enable, `ref_tick`. The block drives a filtered level and one-cycle rising and falling strobes that a downstream edge or level detector can consume.

A two-bit policy field selects how glitches are handled:
- Policy 00 passes the synchronized pin straight through.
- Policy 01 requires stability in both directions. It is the usual choice for edge-triggered interrupts.
- Policy 10 lets falling transitions through at once and filters only rising ones. It suits level-high interrupts.
- Policy 11 is the mirror of 10 and suits level-low interrupts.

Writing a new control word restarts the window. A level that has already been accepted is kept.

Top module: `pin_glitch_filter`

## Requirements
- R1: With policy 00 (bypass), `level_out` follows `pin_raw` with exactly three clock edges of delay: two synchronizer stages and the output register.
- R2: The timebase field `cfg_tbase` sets the unit tick length in `ref_tick` pulses: 00 gives 2, 01 gives 8, 10 gives 512 and 11 gives 2048.
- R3: With policy 01, a pulse of either polarity on the pin propagates only if it lasts at least count × unit + 1 clock cycles (with `ref_tick` high every cycle). A pulse that is one cycle shorter produces no output change.
- R4: With a windowed transition pending, any return of the synchronized pin to the current output level restarts the window from zero.
- R5: With policy 10, a high-to-low transition reaches the output with the bypass latency. A low-to-high transition must satisfy the window.
- R6: With policy 11, a low-to-high transition reaches the output with the bypass latency. A high-to-low transition must satisfy the window.
- R7: A count of 0 under a filtering policy is a zero-length window, so transitions propagate with the bypass latency.
- R8: The window advances only on cycles where `ref_tick` is high. Cycles without it do not count.
- R9: Any change to `cfg_count`, `cfg_tbase` or `cfg_policy` restarts the window. `level_out` keeps its value through the change.
- R10: `rise_pulse` and `fall_pulse` are high for exactly one cycle, in the first cycle `level_out` shows its new value. They are never high together.
- R11: During reset, `level_out`, `rise_pulse` and `fall_pulse` are 0 whatever the pin level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable from the slow reference clock |
| pin_raw | input | 1 | Asynchronous pin level |
| cfg_count | input | CNT_W (4) | Window length in unit ticks |
| cfg_tbase | input | 2 | Unit tick select {large, unit}: 2, 8, 512 or 2048 reference ticks |
| cfg_policy | input | 2 | 00 bypass, 01 filter both, 10 pass falls, 11 pass rises |
| level_out | output | 1 | Filtered, synchronized pin level |
| rise_pulse | output | 1 | One-cycle strobe on a filtered 0-to-1 change |
| fall_pulse | output | 1 | One-cycle strobe on a filtered 1-to-0 change |

## Verification
A fault in the prescaler or the stability counter appears at the ports as a shifted acceptance threshold. A pin pulse at exactly count × unit cycles either leaks through or one cycle longer is swallowed, and this shows within one window plus three cycles. A counter that fails to clear on a bounce or on a new control word shows as an early `rise_pulse`, several cycles before the restarted window should expire. A wrong polarity decode in the glitch policy shows as a transition that reaches `level_out` three edges after the pin instead of a full window later, or the reverse.

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter #(
  parameter int CNT_W   = 4,
  parameter int PRE_W   = 11,
  parameter int TB_LEN0 = 2,
  parameter int TB_LEN1 = 8,
  parameter int TB_LEN2 = 512,
  parameter int TB_LEN3 = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             pin_raw,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [1:0]       cfg_tbase,
  input  logic [1:0]       cfg_policy,
  output logic             level_out,
  output logic             rise_pulse,
  output logic             fall_pulse
);

  localparam logic [1:0] POL_BYPASS  = 2'd0;
  localparam logic [1:0] POL_BOTH    = 2'd1;
  localparam logic [1:0] POL_KEEP_LO = 2'd2;
  localparam logic [1:0] POL_KEEP_HI = 2'd3;
  localparam int         CFG_W       = CNT_W + 4;

  logic [1:0]       sync_q;
  logic [CFG_W-1:0] cfg_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_last;
  logic [CNT_W-1:0] stab_q;
  logic             filt_q;
  logic             filt_d1;
  logic             pin_s;
  logic             cfg_chg;
  logic             differ;
  logic             pass_now;
  logic             window_done;

  assign pin_s       = sync_q[1];
  assign cfg_chg     = {cfg_count, cfg_tbase, cfg_policy} != cfg_q;
  assign differ      = pin_s != filt_q;
  assign pass_now    = (cfg_policy == POL_KEEP_LO && !pin_s) ||
                       (cfg_policy == POL_KEEP_HI &&  pin_s);
  assign window_done = stab_q == cfg_count;

  always_comb begin
    case (cfg_tbase)
      2'd0:    pre_last = PRE_W'(TB_LEN0 - 1);
      2'd1:    pre_last = PRE_W'(TB_LEN1 - 1);
      2'd2:    pre_last = PRE_W'(TB_LEN2 - 1);
      default: pre_last = PRE_W'(TB_LEN3 - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cfg_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_raw};
      cfg_q  <= {cfg_count, cfg_tbase, cfg_policy};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      stab_q <= '0;
      filt_q <= 1'b0;
    end else if (cfg_policy == POL_BYPASS) begin
      filt_q <= pin_s;
      pre_q  <= '0;
      stab_q <= '0;
    end else if (cfg_chg || !differ) begin
      pre_q  <= '0;
      stab_q <= '0;
    end else if (pass_now || window_done) begin
      filt_q <= pin_s;
      pre_q  <= '0;
      stab_q <= '0;
    end else if (ref_tick) begin
      if (pre_q == pre_last) begin
        pre_q  <= '0;
        stab_q <= stab_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filt_d1 <= 1'b0;
    else        filt_d1 <= filt_q;
  end

  assign level_out  = filt_q;
  assign rise_pulse = filt_q & ~filt_d1;
  assign fall_pulse = ~filt_q & filt_d1;

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 1'b1;
  end

  p_bypass_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && $past(cfg_policy) == POL_BYPASS) |-> level_out == $past(pin_raw, 3));

  p_window_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_policy == POL_BOTH && !cfg_chg && differ && !window_done) |=> $stable(level_out));

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_policy != POL_BYPASS && !differ) |=> stab_q == '0);

  p_fast_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_policy == POL_KEEP_LO && !cfg_chg && !pin_s && level_out) |=> !level_out);

  p_fast_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_policy == POL_KEEP_HI && !cfg_chg && pin_s && !level_out) |=> level_out);

  p_tick_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_policy == POL_BOTH && !cfg_chg && differ && !window_done && !ref_tick) |=> $stable(stab_q));

  p_cfg_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chg && cfg_policy != POL_BYPASS) |=> $stable(level_out));

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_pulse, fall_pulse}));

endmodule

// File: tb/pin_glitch_filter_tb_top.sv
module pin_glitch_filter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_tick = 1'b1;
  logic       pin_raw;
  logic [3:0] cfg_count;
  logic [1:0] cfg_tbase;
  logic [1:0] cfg_policy;
  logic       level_out;
  logic       rise_pulse;
  logic       fall_pulse;

  int  checks   = 0;
  int  fails    = 0;
  int  rc       = 0;
  int  fc       = 0;
  bit  finished = 1'b0;
  bit  tick_mode = 1'b0;
  logic [1:0] div = '0;

  always #10 clk = ~clk;

  pin_glitch_filter dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pin_raw(pin_raw),
    .cfg_count(cfg_count), .cfg_tbase(cfg_tbase), .cfg_policy(cfg_policy),
    .level_out(level_out), .rise_pulse(rise_pulse), .fall_pulse(fall_pulse)
  );

  always @(negedge clk) begin
    div      <= div + 1'b1;
    ref_tick <= tick_mode ? (div == 2'd0) : 1'b1;
    if (rise_pulse) rc <= rc + 1;
    if (fall_pulse) fc <= fc + 1;
  end

  // {policy, tbase, count, start level, pulse width, expect propagation}
  localparam int NVEC = 19;
  localparam logic [21:0] VEC [NVEC] = '{
    {2'd1, 2'd0, 4'd3,  1'b0, 12'd6,    1'b0},
    {2'd1, 2'd0, 4'd3,  1'b0, 12'd7,    1'b1},
    {2'd1, 2'd0, 4'd3,  1'b1, 12'd6,    1'b0},
    {2'd1, 2'd0, 4'd3,  1'b1, 12'd7,    1'b1},
    {2'd1, 2'd1, 4'd2,  1'b0, 12'd16,   1'b0},
    {2'd1, 2'd1, 4'd2,  1'b0, 12'd17,   1'b1},
    {2'd0, 2'd1, 4'd5,  1'b0, 12'd1,    1'b1},
    {2'd2, 2'd0, 4'd4,  1'b1, 12'd1,    1'b1},
    {2'd2, 2'd0, 4'd4,  1'b0, 12'd8,    1'b0},
    {2'd2, 2'd0, 4'd4,  1'b0, 12'd9,    1'b1},
    {2'd3, 2'd0, 4'd4,  1'b0, 12'd1,    1'b1},
    {2'd3, 2'd0, 4'd4,  1'b1, 12'd8,    1'b0},
    {2'd3, 2'd0, 4'd4,  1'b1, 12'd9,    1'b1},
    {2'd1, 2'd2, 4'd1,  1'b0, 12'd512,  1'b0},
    {2'd1, 2'd2, 4'd1,  1'b0, 12'd513,  1'b1},
    {2'd1, 2'd3, 4'd1,  1'b0, 12'd2049, 1'b1},
    {2'd1, 2'd0, 4'd0,  1'b0, 12'd1,    1'b1},
    {2'd1, 2'd1, 4'd15, 1'b0, 12'd121,  1'b1},
    {2'd1, 2'd1, 4'd15, 1'b0, 12'd120,  1'b0}
  };

  task automatic tick_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int len_of(logic [1:0] tb);
    case (tb)
      2'd0:    return 2;
      2'd1:    return 8;
      2'd2:    return 512;
      default: return 2048;
    endcase
  endfunction

  task automatic set_cfg(logic [1:0] pol, logic [1:0] tb, logic [3:0] cnt);
    cfg_policy = pol;
    cfg_tbase  = tb;
    cfg_count  = cnt;
  endtask

  task automatic run_vec(logic [21:0] v);
    logic [1:0]  pol   = v[21:20];
    logic [1:0]  tb    = v[19:18];
    logic [3:0]  cnt   = v[17:14];
    logic        start = v[13];
    int          w     = int'(v[12:1]);
    int          exp   = int'(v[0]);
    int          win   = len_of(tb) * int'(cnt) + 20;
    string       tag;
    if (cnt == 4'd0 && pol != 2'd0) tag = "R7";
    else if (pol == 2'd0)           tag = "R1";
    else if (pol == 2'd2)           tag = "R5";
    else if (pol == 2'd3)           tag = "R6";
    else if (tb != 2'd0)            tag = "R2";
    else                            tag = "R3";
    set_cfg(pol, tb, cnt);
    pin_raw = start;
    tick_n(win);
    check({tag, " settle"}, int'(level_out), int'(start));
    rc = 0;
    fc = 0;
    pin_raw = ~start;
    tick_n(w);
    pin_raw = start;
    tick_n(win);
    check({tag, " R10 rise count"}, rc, exp);
    check({tag, " R10 fall count"}, fc, exp);
    check({tag, " final level"}, int'(level_out), int'(start));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    pin_raw = 1'b1;
    set_cfg(2'd0, 2'd0, 4'd0);
    tick_n(3);
    check("R11 level in reset", int'(level_out), 0);
    check("R11 rise in reset", int'(rise_pulse), 0);
    check("R11 fall in reset", int'(fall_pulse), 0);
    rst_n = 1'b1;
    tick_n(2);
    check("R1 rise not before third edge", int'(level_out), 0);
    tick_n(1);
    check("R1 rise at third edge", int'(level_out), 1);
    check("R10 rise strobe with level", int'(rise_pulse), 1);
    tick_n(1);
    check("R10 rise strobe one cycle", int'(rise_pulse), 0);
    pin_raw = 1'b0;
    tick_n(2);
    check("R1 fall not before third edge", int'(level_out), 1);
    tick_n(1);
    check("R1 fall at third edge", int'(level_out), 0);
    check("R10 fall strobe with level", int'(fall_pulse), 1);
    tick_n(5);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // R4: bounce restarts the window
    set_cfg(2'd1, 2'd0, 4'd3);
    pin_raw = 1'b0;
    tick_n(30);
    rc = 0;
    pin_raw = 1'b1; tick_n(5);
    pin_raw = 1'b0; tick_n(1);
    pin_raw = 1'b1; tick_n(5);
    pin_raw = 1'b0; tick_n(20);
    check("R4 bounced pulse rise count", rc, 0);
    check("R4 bounced pulse level", int'(level_out), 0);

    // R8: only ref_tick cycles advance the window
    set_cfg(2'd1, 2'd0, 4'd2);
    tick_mode = 1'b1;
    tick_n(30);
    pin_raw = 1'b1;
    tick_n(10);
    check("R8 sparse ticks not yet accepted", int'(level_out), 0);
    tick_n(14);
    check("R8 sparse ticks accepted", int'(level_out), 1);
    tick_mode = 1'b0;

    // R9: control word change restarts window, output held
    set_cfg(2'd1, 2'd0, 4'd4);
    pin_raw = 1'b0;
    tick_n(30);
    check("R9 setup level", int'(level_out), 0);
    pin_raw = 1'b1;
    tick_n(6);
    cfg_count = 4'd5;
    tick_n(1);
    check("R9 level kept on change", int'(level_out), 0);
    tick_n(7);
    check("R9 window restarted", int'(level_out), 0);
    tick_n(4);
    check("R9 accepted after new window", int'(level_out), 1);
    check("R10 rise strobe on accept", int'(rise_pulse), 1);
    tick_n(1);
    check("R10 rise strobe dropped", int'(rise_pulse), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule